// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single counter channel of a legacy-style interval timer. It has a 16-bit down-counter that advances only on clock edges where a one-cycle `tick` strobe is high. The strobe comes from a clock divider outside the channel. A `gate` input qualifies or triggers counting, depending on the mode. An output pin carries the mode's waveform.

A register front end writes a new count, mode and number base in one cycle with `load_en`. That write re-arms the channel. The channel reports its live count, its output level and a flag that shows whether a loaded count is still in force.

Six counting modes are provided: a software-started one-shot, a gate-triggered one-shot, a rate generator, a square-wave generator that steps by two, a software strobe and a gate-triggered strobe. Counting is either plain binary or four packed decimal digits.

Top module: `pit_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the channel clears: `out_level` is 0, `count_value` is 0 and `count_loaded` is 0.
- R2: A write (`load_en` high) takes effect at that edge. `count_loaded` becomes 1, and `count_value` shows the written count (even-rounded in mode 3). `out_level` becomes 0 for mode 0 and 1 for every other mode. The mode field codes 0..5 select modes 0..5, code 6 acts as mode 2 and code 7 acts as mode 3. A pending gate trigger is discarded by a write.
- R3: Mode 0 (software one-shot). Each tick while `gate` is high decrements the count, starting with the first tick after the write. With `gate` low the count and output hold. When the count reaches zero, `out_level` goes to 1 and counting stops.
- R4: Mode 1 (triggered one-shot). A rising edge of `gate` is latched until the next tick. That tick reloads the count and drives `out_level` low. Later ticks decrement whatever the gate level is. At zero, `out_level` returns to 1. A new trigger during the countdown reloads the count.
- R5: Mode 2 (rate generator). While `gate` is high, each tick decrements the count. A tick that leaves the count at 1 drives `out_level` low, and the next tick reloads the written count and drives it high again. A low `gate` halts counting and forces `out_level` to 1 on every clock.
- R6: Mode 3 (square wave) with an even count N. The count steps down by two per tick while `gate` is high. `out_level` starts high and toggles each time the count reaches zero, giving N/2 ticks per half-period. The count reloads at each toggle.
- R7: Mode 3 with an odd count N (N ≥ 3). The counter runs from N−1. The high half lasts (N+1)/2 ticks because the count holds one extra tick at zero before the toggle. The low half lasts (N−1)/2 ticks.
- R8: Mode 4 (software strobe). `out_level` stays high while ticks with `gate` high count down. When the count reaches zero, `out_level` goes low until the next tick and then returns high. The count is not reloaded.
- R9: Mode 5 (triggered strobe). A latched rising edge of `gate` reloads the count on the next tick. Later ticks decrement whatever the gate level is. At zero, `out_level` pulses low for one tick. The count is not reloaded.
- R10: With `load_bcd` = 1, the count holds four decimal digits in 4-bit nibbles, least significant at bits 3:0. Each digit stays within 0..9 and borrows into the next digit, so 0100 decrements to 0099.
- R11: A written count of zero acts as the largest count. In binary, 65536 ticks pass before the count returns to zero (it wraps to FFFF first). In decimal, 10000 ticks pass (it wraps to 9999 first).
- R12: `count_loaded` drops to 0 when a mode 0, 1, 4 or 5 countdown reaches zero. It stays 1 in modes 2 and 3, and the next write sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle count strobe from the external divider |
| gate | input | 1 | Gate level, enable or trigger depending on mode |
| load_en | input | 1 | Write strobe for count, mode and base |
| load_count | input | 16 | Count to load (binary, or four decimal digits) |
| load_mode | input | 3 | Counting mode code |
| load_bcd | input | 1 | 1 selects decimal counting, 0 selects binary |
| out_level | output | 1 | Channel output pin |
| count_value | output | 16 | Current count |
| count_loaded | output | 1 | A loaded count is still in force |

## Verification
The live count is exposed on every clock, so a wrong decrement step, a broken decimal borrow or a bad reload value shows as a `count_value` mismatch at the first tick that uses it. A fault in trigger latching or gate qualification shows within one tick, either as a count that moves when it should hold or as a countdown that fails to start. Faults in mode 3 phase handling or in the odd-count extra tick only shift `out_level` edges. They are caught at the first half-period boundary, which is at most N/2+1 ticks after the write.

// File: rtl/pit_pkg.sv
// Package: shared mode encoding and mode-code normalisation for the timer channel.
// Assumes a 3-bit mode field; codes 6 and 7 alias modes 2 and 3.
package pit_pkg;

    typedef enum logic [2:0] {
        M_ONESHOT      = 3'd0,
        M_TRIG_ONESHOT = 3'd1,
        M_RATE         = 3'd2,
        M_SQUARE       = 3'd3,
        M_SW_STROBE    = 3'd4,
        M_HW_STROBE    = 3'd5
    } pit_mode_e;

    // Map a raw mode code onto one of the six modes.
    function automatic pit_mode_e pit_norm_mode(input logic [2:0] raw);
        if (raw[1]) begin
            return pit_mode_e'({1'b0, raw[1:0]});
        end
        return pit_mode_e'(raw);
    endfunction

endpackage

// File: rtl/pit_decrementer.sv
// Module: combinational down-step of the count by one or two,
// in binary or in packed decimal digits with borrow between digits.
// Assumes CNT_W is a multiple of four and decimal inputs hold valid digits.
module pit_decrementer #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] value,
    input  logic             step2,
    input  logic             bcd,
    output logic [CNT_W-1:0] result
);
    localparam int DIGITS = CNT_W / 4;

    logic [CNT_W-1:0] bin_res;
    logic [CNT_W-1:0] dec_res;
    logic [DIGITS-1:1] brw;

    // Binary wrap-around subtraction of one or two.
    assign bin_res = value - {{(CNT_W-2){1'b0}}, step2, ~step2};

    // One subtractor per decimal digit, borrow rippling upward.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [1:0] sub;
        logic [4:0] diff;
        if (g == 0) begin : g_low
            assign sub = {step2, ~step2};
        end else begin : g_up
            assign sub = {1'b0, brw[g]};
        end
        assign diff = {1'b0, value[4*g+3:4*g]} - {3'b000, sub};
        assign dec_res[4*g+3:4*g] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
        if (g < DIGITS - 1) begin : g_brw
            assign brw[g+1] = diff[4];
        end
    end

    // Pick the arithmetic for the active base.
    assign result = bcd ? dec_res : bin_res;

endmodule

// File: rtl/pit_gate_edge.sv
// Module: detects rising edges of the gate and holds a trigger until the next tick.
// Assumes gate is already synchronous to clk; a write discards any held trigger.
module pit_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic tick,
    input  logic load_en,
    output logic trig
);
    logic gate_q;
    logic pend_q;
    logic rise;

    assign rise = gate & ~gate_q;
    assign trig = pend_q | rise;

    // Remember the previous gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    // Hold a trigger until a tick consumes it or a write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (load_en || tick)  pend_q <= 1'b0;
        else if (rise)             pend_q <= 1'b1;
    end

    p_trigger_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !tick && gate && !gate_q) |=> pend_q);

    p_trigger_dropped_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !pend_q);

endmodule

// File: rtl/pit_counter_ctl.sv
// Module: count register, output pin and loaded flag for all six modes.
// Assumes trig is a one-cycle-valid trigger from the gate edge unit and
// dec_res is this cycle's count minus one (minus two in mode 3).
module pit_counter_ctl
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             trig,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_count,
    input  logic [2:0]       load_mode,
    input  logic             load_bcd,
    input  logic [CNT_W-1:0] dec_res,
    output logic [CNT_W-1:0] cnt,
    output logic             step2,
    output logic             bcd,
    output logic             out_level,
    output logic             count_loaded
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pit_mode_e        mode_q;
    pit_mode_e        new_mode;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] even_reload;
    logic             bcd_q;
    logic             out_q;
    logic             run_q;
    logic             loaded_q;
    logic             hold_q;
    logic             dec_zero;

    assign new_mode    = pit_norm_mode(load_mode);
    assign even_reload = {reload_q[CNT_W-1:1], 1'b0};
    assign dec_zero    = (dec_res == '0);

    assign cnt          = cnt_q;
    assign step2        = (mode_q == M_SQUARE);
    assign bcd          = bcd_q;
    assign out_level    = out_q;
    assign count_loaded = loaded_q;

    // Mode state machine: a write re-arms, otherwise ticks advance the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_ONESHOT;
            cnt_q    <= '0;
            reload_q <= '0;
            bcd_q    <= 1'b0;
            out_q    <= 1'b0;
            run_q    <= 1'b0;
            loaded_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (load_en) begin
            mode_q   <= new_mode;
            reload_q <= load_count;
            bcd_q    <= load_bcd;
            loaded_q <= 1'b1;
            hold_q   <= 1'b0;
            cnt_q    <= (new_mode == M_SQUARE) ? {load_count[CNT_W-1:1], 1'b0} : load_count;
            out_q    <= (new_mode != M_ONESHOT);
            run_q    <= (new_mode == M_ONESHOT) || (new_mode == M_RATE) ||
                        (new_mode == M_SQUARE)  || (new_mode == M_SW_STROBE);
        end else begin
            if (tick) begin
                case (mode_q)
                    M_ONESHOT: begin
                        if (run_q && gate) begin
                            cnt_q <= dec_res;
                            if (dec_zero) begin
                                out_q    <= 1'b1;
                                run_q    <= 1'b0;
                                loaded_q <= 1'b0;
                            end
                        end
                    end
                    M_TRIG_ONESHOT: begin
                        if (trig) begin
                            cnt_q <= reload_q;
                            out_q <= 1'b0;
                            run_q <= 1'b1;
                        end else if (run_q) begin
                            cnt_q <= dec_res;
                            if (dec_zero) begin
                                out_q    <= 1'b1;
                                run_q    <= 1'b0;
                                loaded_q <= 1'b0;
                            end
                        end
                    end
                    M_RATE: begin
                        if (gate) begin
                            if (cnt_q == ONE) begin
                                cnt_q <= reload_q;
                                out_q <= 1'b1;
                            end else begin
                                cnt_q <= dec_res;
                                if (dec_res == ONE) out_q <= 1'b0;
                            end
                        end
                    end
                    M_SQUARE: begin
                        if (gate) begin
                            if (hold_q) begin
                                hold_q <= 1'b0;
                                out_q  <= ~out_q;
                                cnt_q  <= even_reload;
                            end else begin
                                cnt_q <= dec_res;
                                if (dec_zero) begin
                                    if (out_q && reload_q[0]) begin
                                        hold_q <= 1'b1;
                                    end else begin
                                        out_q <= ~out_q;
                                        cnt_q <= even_reload;
                                    end
                                end
                            end
                        end
                    end
                    M_SW_STROBE: begin
                        if (!out_q) begin
                            out_q <= 1'b1;
                        end else if (run_q && gate) begin
                            cnt_q <= dec_res;
                            if (dec_zero) begin
                                out_q    <= 1'b0;
                                run_q    <= 1'b0;
                                loaded_q <= 1'b0;
                            end
                        end
                    end
                    M_HW_STROBE: begin
                        if (!out_q) begin
                            out_q <= 1'b1;
                        end else if (trig) begin
                            cnt_q <= reload_q;
                            run_q <= 1'b1;
                        end else if (run_q) begin
                            cnt_q <= dec_res;
                            if (dec_zero) begin
                                out_q    <= 1'b0;
                                run_q    <= 1'b0;
                                loaded_q <= 1'b0;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
            if (mode_q == M_RATE && !gate) out_q <= 1'b1;
        end
    end

    p_load_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> loaded_q);

    p_mode0_low_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && new_mode == M_ONESHOT) |=> !out_q);

    p_count_frozen_gate_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && mode_q == M_ONESHOT && !gate) |=> $stable(cnt_q));

    p_rate_gate_low_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && mode_q == M_RATE && !gate) |=> out_q);

    p_strobe_one_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && tick && !out_q && (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE)) |=> out_q);

    p_flag_clear_oneshot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loaded_q) |-> (mode_q == M_ONESHOT || mode_q == M_TRIG_ONESHOT ||
                             mode_q == M_SW_STROBE || mode_q == M_HW_STROBE));

endmodule

// File: rtl/pit_channel.sv
// Module: top of one interval timer channel; joins gate edge capture,
// the decrementer and the mode controller.
// Assumes tick is a one-cycle strobe synchronous to clk.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_count,
    input  logic [2:0]       load_mode,
    input  logic             load_bcd,
    output logic             out_level,
    output logic [CNT_W-1:0] count_value,
    output logic             count_loaded
);
    logic             trig;
    logic             step2;
    logic             bcd;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dec_res;

    pit_gate_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate),
        .tick    (tick),
        .load_en (load_en),
        .trig    (trig)
    );

    pit_decrementer #(.CNT_W(CNT_W)) u_dec (
        .value  (cnt),
        .step2  (step2),
        .bcd    (bcd),
        .result (dec_res)
    );

    pit_counter_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .gate         (gate),
        .trig         (trig),
        .load_en      (load_en),
        .load_count   (load_count),
        .load_mode    (load_mode),
        .load_bcd     (load_bcd),
        .dec_res      (dec_res),
        .cnt          (cnt),
        .step2        (step2),
        .bcd          (bcd),
        .out_level    (out_level),
        .count_loaded (count_loaded)
    );

    assign count_value = cnt;

endmodule

// File: tb/pit_channel_tb.sv
// Bench: behavioural integer model stepped at each rising edge, compared at each falling edge.
module pit_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_count = '0;
    logic [2:0]  load_mode = '0;
    logic        load_bcd = 1'b0;
    logic        out_level;
    logic [15:0] count_value;
    logic        count_loaded;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    pit_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .load_en(load_en), .load_count(load_count), .load_mode(load_mode),
        .load_bcd(load_bcd), .out_level(out_level), .count_value(count_value),
        .count_loaded(count_loaded)
    );

    always #10 clk = ~clk;

    // Reference model state (integers, not the design's structure).
    int m_n = 0, m_reload = 0, m_mode = 0, m_bcd = 0, m_out = 0;
    int m_run = 0, m_loaded = 0, m_hold = 0, m_gq = 0, m_pend = 0;

    function automatic int from_bcd(input logic [15:0] v);
        return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    endfunction

    function automatic logic [15:0] to_bcd(input int n);
        logic [15:0] r;
        r[15:12] = 4'((n / 1000) % 10);
        r[11:8]  = 4'((n / 100) % 10);
        r[7:4]   = 4'((n / 10) % 10);
        r[3:0]   = 4'(n % 10);
        return r;
    endfunction

    // Advance the model by one clock edge.
    always @(posedge clk) begin
        int md, lim, d1, d2, even, rise, trg;
        if (!rst_n) begin
            m_n = 0; m_reload = 0; m_mode = 0; m_bcd = 0; m_out = 0;
            m_run = 0; m_loaded = 0; m_hold = 0; m_gq = 0; m_pend = 0;
        end else begin
            rise = (gate && !m_gq) ? 1 : 0;
            trg  = (m_pend || rise) ? 1 : 0;
            if (load_en) begin
                md = int'(load_mode);
                if (md == 6) md = 2;
                if (md == 7) md = 3;
                m_mode = md;
                m_bcd = load_bcd;
                m_reload = load_bcd ? from_bcd(load_count) : int'(load_count);
                m_n = (md == 3) ? m_reload - (m_reload % 2) : m_reload;
                m_out = (md == 0) ? 0 : 1;
                m_run = (md == 0 || md == 2 || md == 3 || md == 4) ? 1 : 0;
                m_loaded = 1;
                m_hold = 0;
            end else begin
                lim = m_bcd ? 10000 : 65536;
                d1 = (m_n - 1 + lim) % lim;
                d2 = (m_n - 2 + lim) % lim;
                even = m_reload - (m_reload % 2);
                if (tick) begin
                    case (m_mode)
                        0: if (m_run && gate) begin
                            m_n = d1;
                            if (m_n == 0) begin m_out = 1; m_run = 0; m_loaded = 0; end
                        end
                        1: if (trg) begin
                            m_n = m_reload; m_out = 0; m_run = 1;
                        end else if (m_run) begin
                            m_n = d1;
                            if (m_n == 0) begin m_out = 1; m_run = 0; m_loaded = 0; end
                        end
                        2: if (gate) begin
                            if (m_n == 1) begin m_n = m_reload; m_out = 1; end
                            else begin m_n = d1; if (m_n == 1) m_out = 0; end
                        end
                        3: if (gate) begin
                            if (m_hold) begin m_hold = 0; m_out = !m_out; m_n = even; end
                            else begin
                                m_n = d2;
                                if (m_n == 0) begin
                                    if (m_out && (m_reload % 2) == 1) m_hold = 1;
                                    else begin m_out = !m_out; m_n = even; end
                                end
                            end
                        end
                        4: if (!m_out) m_out = 1;
                           else if (m_run && gate) begin
                               m_n = d1;
                               if (m_n == 0) begin m_out = 0; m_run = 0; m_loaded = 0; end
                           end
                        5: if (!m_out) m_out = 1;
                           else if (trg) begin m_n = m_reload; m_run = 1; end
                           else if (m_run) begin
                               m_n = d1;
                               if (m_n == 0) begin m_out = 0; m_run = 0; m_loaded = 0; end
                           end
                        default: ;
                    endcase
                end
                if (m_mode == 2 && !gate) m_out = 1;
            end
            if (load_en || tick) m_pend = 0;
            else if (rise) m_pend = 1;
            m_gq = gate;
        end
    end

    // Compare all outputs against the model on every falling edge.
    always @(negedge clk) begin
        logic [15:0] exp_cnt;
        if (!done) begin
            exp_cnt = m_bcd ? to_bcd(m_n) : 16'(m_n);
            checks++;
            if (count_value !== exp_cnt || out_level !== m_out[0] || count_loaded !== m_loaded[0]) begin
                errors++;
                $display("FAIL %s: count=%h out=%b loaded=%b expected count=%h out=%0d loaded=%0d",
                         cur_req, count_value, out_level, count_loaded, exp_cnt, m_out, m_loaded);
            end
        end
    end

    task automatic check_point(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] c, input logic [2:0] md, input logic b);
        load_en = 1'b1; load_count = c; load_mode = md; load_bcd = b; tick = 1'b0;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            tick = ((i % period) == period - 1);
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_point("R1", {13'd0, out_level, count_loaded, 1'b0}, 16'd0);
        check_point("R1", count_value, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R2";
        do_load(16'd9, 3'd7, 1'b0);
        check_point("R2", count_value, 16'd8);
        check_point("R2", {15'd0, out_level}, 16'd1);
        run(12, 1);
        do_load(16'd5, 3'd6, 1'b0);
        run(12, 2);

        cur_req = "R3";
        gate = 1'b1;
        do_load(16'd3, 3'd0, 1'b0);
        check_point("R3", {15'd0, out_level}, 16'd0);
        run(3, 1);
        check_point("R3", {15'd0, out_level}, 16'd1);
        check_point("R12", {15'd0, count_loaded}, 16'd0);
        do_load(16'd6, 3'd0, 1'b0);
        run(4, 2);
        gate = 1'b0;
        run(6, 1);
        gate = 1'b1;
        run(10, 2);

        cur_req = "R4";
        gate = 1'b0;
        do_load(16'd4, 3'd1, 1'b0);
        run(5, 1);
        gate = 1'b1; run(1, 3);
        gate = 1'b0; run(5, 2);
        gate = 1'b1; run(1, 1);
        gate = 1'b0; run(3, 1);
        gate = 1'b1; run(1, 1);
        gate = 1'b0; run(10, 1);

        cur_req = "R5";
        gate = 1'b1;
        do_load(16'd4, 3'd2, 1'b0);
        run(14, 1);
        gate = 1'b0; run(4, 1);
        gate = 1'b1; run(20, 2);

        cur_req = "R6";
        do_load(16'd6, 3'd3, 1'b0);
        run(20, 1);
        gate = 1'b0; run(3, 1);
        gate = 1'b1; run(10, 2);

        cur_req = "R7";
        do_load(16'd5, 3'd3, 1'b0);
        run(24, 1);
        do_load(16'd7, 3'd3, 1'b0);
        run(30, 1);

        cur_req = "R8";
        do_load(16'd3, 3'd4, 1'b0);
        run(2, 1);
        gate = 1'b0; run(3, 1);
        gate = 1'b1; run(6, 1);
        check_point("R8", {15'd0, out_level}, 16'd1);

        cur_req = "R9";
        gate = 1'b0;
        do_load(16'd3, 3'd5, 1'b0);
        run(4, 1);
        gate = 1'b1; run(1, 2);
        gate = 1'b0; run(8, 1);
        gate = 1'b1; run(1, 1);
        gate = 1'b0; run(8, 1);

        cur_req = "R10";
        gate = 1'b1;
        do_load(16'h0102, 3'd0, 1'b1);
        run(3, 1);
        check_point("R10", count_value, 16'h0099);
        do_load(16'h0012, 3'd2, 1'b1);
        run(30, 1);
        do_load(16'h0011, 3'd3, 1'b1);
        run(30, 1);

        cur_req = "R12";
        do_load(16'd3, 3'd2, 1'b0);
        run(12, 1);
        check_point("R12", {15'd0, count_loaded}, 16'd1);

        cur_req = "R11";
        do_load(16'h0000, 3'd0, 1'b0);
        run(1, 1);
        check_point("R11", count_value, 16'hFFFF);
        run(65534, 1);
        check_point("R11", {15'd0, out_level}, 16'd0);
        run(1, 1);
        check_point("R11", {15'd0, out_level}, 16'd1);
        do_load(16'h0000, 3'd0, 1'b1);
        run(1, 1);
        check_point("R11", count_value, 16'h9999);
        run(9999, 1);
        check_point("R11", {15'd0, out_level}, 16'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(190000 * 20);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule